// File: doc/BRIEF.md
# Two-Tier Interrupt Priority Controller

This block merges external interrupt requests with fifteen internal peripheral requests and presents the processor with one registered, active-low 3-bit priority level. External requests arrive in one of two ways, selected by a mode input. In encoded mode, a 3-bit active-low level code may request any level except 4. In dedicated mode, three discrete active-low pins request levels 7, 6 and 1.

All internal requests share level 4. Within that level they are ordered by a fixed table, and each has a mask bit. On an acknowledge of level 4 the controller returns the 4-bit index of the winning internal source. Single-event sources are held in pending latches that the acknowledge clears. Multi-event sources reflect the state of their own event registers, so the acknowledge does not clear them.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `ipl_no` is 3'b111 (no request) and `iack_idx_o` is 15, and all pending latches are clear.
- R2: `ipl_no` is registered and carries 7 minus the winning level. Level 7 is 3'b000 and level 1 is 3'b110. When nothing is requested it is 3'b111.
- R3: In encoded mode (`dedicated_mode_i`=0), `ext_ipl_ni` requests level 7 minus its value. Code 3'b111 means no request. Code 3'b011 (level 4) is ignored and treated as no request. The dedicated pins are ignored in this mode.
- R4: In dedicated mode, `ded_irq7_ni`, `ded_irq6_ni` and `ded_irq1_ni` (active low) request levels 7, 6 and 1, and the highest active pin wins. `ext_ipl_ni` is ignored in this mode.
- R5: External inputs pass through two synchronizing flops. A change made before clock edge k shows on `ipl_no` after edge k+2. The mode input itself is not synchronized.
- R6: Any unmasked pending internal source requests level 4. The output level is the larger of the external level and 4.
- R7: Internal source indices run in priority order, with 0 the highest: 0 pin irq 3, 1 pin irq 2, 2 serial ch 1, 3 serial DMA bus error, 4 general DMA, 5 serial ch 2, 6 timer 1, 7 serial ch 3, 8 pin irq 1, 9 timer 2, 10 serial peripheral port, 11 timer 3, 12 mgmt ch 1, 13 mgmt ch 2, 14 pin irq 0. Index 15 is the lowest, error slot.
- R8: When `int_mask_i[i]`=1, source i does not request level 4 and is not selected. It stays pending, so unmasking it later makes it request again.
- R9: `iack_i` with `iack_level_i`=4 loads `iack_idx_o` on the next edge with the highest-priority unmasked pending index, or with 15 if there is none. An acknowledge at any other level changes neither `iack_idx_o` nor any pending state.
- R10: A single-event source (every index not listed in R11) latches on a one-cycle `int_req_i` pulse. A level-4 acknowledge that selects it clears the latch. A new pulse in the same cycle keeps it pending.
- R11: Multi-event sources (indices 2, 4, 5, 6, 7 and 9) are pending exactly while `int_req_i[i]` is high. An acknowledge does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dedicated_mode_i | input | 1 | 1 selects the dedicated-pin external mode |
| ext_ipl_ni | input | 3 | Encoded external level, active low |
| ded_irq7_ni | input | 1 | Dedicated level-7 request, active low |
| ded_irq6_ni | input | 1 | Dedicated level-6 request, active low |
| ded_irq1_ni | input | 1 | Dedicated level-1 request, active low |
| int_req_i | input | 15 | Internal requests: pulses for single-event sources, levels for multi-event sources |
| int_mask_i | input | 15 | Per-source mask, 1 = masked |
| iack_i | input | 1 | Acknowledge strobe |
| iack_level_i | input | 3 | Level being acknowledged |
| ipl_no | output | 3 | Registered priority level, active low |
| iack_idx_o | output | 4 | Index of the source granted at the last level-4 acknowledge |

## Verification
The encoded input is swept through all eight codes, and the dedicated pins through their combinations. This separates the level encoding from the exclusion of level 4, and shows which input each mode ignores. Internal pulses are mixed with external levels above and below 4, which exercises the maximum rule.

Several sources made pending together and acknowledged in turn expose the fixed order and the single-event clearing. Held multi-event levels show that an acknowledge leaves them standing. Masking, same-cycle re-pulse, non-4 acknowledges and a long random phase against the behavioural model cover the remaining corners.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned NSRC  = 15;
  localparam int unsigned IDXW  = 4;
  // sources with their own event register (not cleared by acknowledge)
  localparam logic [NSRC-1:0] MULTI_EVT = 15'h02F4;
  localparam logic [IDXW-1:0] IDX_NONE  = 4'hF;
  localparam logic [2:0]      LVL_INT   = 3'd4;
endpackage

// File: rtl/irq_ext_decode.sv
module irq_ext_decode (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dedicated_mode_i,
  input  logic [2:0] ext_ipl_ni,
  input  logic       ded_irq7_ni,
  input  logic       ded_irq6_ni,
  input  logic       ded_irq1_ni,
  output logic [2:0] lvl_o
);
  localparam int unsigned SW = 6;
  logic [SW-1:0] raw, s1_q, s2_q;
  logic [2:0]    enc_lvl;

  assign raw = {ded_irq1_ni, ded_irq6_ni, ded_irq7_ni, ext_ipl_ni};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    enc_lvl = 3'd7 - s2_q[2:0];
    if (enc_lvl == 3'd4) enc_lvl = 3'd0;  // level 4 reserved for internal
    if (!dedicated_mode_i)  lvl_o = enc_lvl;
    else if (!s2_q[3])      lvl_o = 3'd7;
    else if (!s2_q[4])      lvl_o = 3'd6;
    else if (!s2_q[5])      lvl_o = 3'd1;
    else                    lvl_o = 3'd0;
  end
endmodule

// File: rtl/irq_int_arb.sv
module irq_int_arb
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_SRC = NSRC,
  parameter int unsigned IDX_W = IDXW,
  parameter logic [N_SRC-1:0] MULTI = MULTI_EVT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] act_o,
  output logic [IDX_W-1:0] sel_o
);
  localparam logic [IDX_W-1:0] NONE = {IDX_W{1'b1}};

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    if (MULTI[g]) begin : g_multi
      assign pend_o[g] = req_i[g];
    end else begin : g_single
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       bit_q <= 1'b0;
        else if (req_i[g]) bit_q <= 1'b1;
        else if (clr_i[g]) bit_q <= 1'b0;
      end
      assign pend_o[g] = bit_q;
    end
  end

  assign act_o = pend_o & ~mask_i;

  always_comb begin
    sel_o = NONE;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (act_o[i]) sel_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_SRC = NSRC,
  parameter int unsigned IDX_W = IDXW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dedicated_mode_i,
  input  logic [2:0]       ext_ipl_ni,
  input  logic             ded_irq7_ni,
  input  logic             ded_irq6_ni,
  input  logic             ded_irq1_ni,
  input  logic [N_SRC-1:0] int_req_i,
  input  logic [N_SRC-1:0] int_mask_i,
  input  logic             iack_i,
  input  logic [2:0]       iack_level_i,
  output logic [2:0]       ipl_no,
  output logic [IDX_W-1:0] iack_idx_o
);
  localparam logic [IDX_W-1:0] NONE = {IDX_W{1'b1}};

  logic [2:0]       ext_lvl, win_lvl;
  logic [N_SRC-1:0] pend, act, clr;
  logic [IDX_W-1:0] sel_idx;
  logic             ack4;

  irq_ext_decode u_ext (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .dedicated_mode_i (dedicated_mode_i),
    .ext_ipl_ni       (ext_ipl_ni),
    .ded_irq7_ni      (ded_irq7_ni),
    .ded_irq6_ni      (ded_irq6_ni),
    .ded_irq1_ni      (ded_irq1_ni),
    .lvl_o            (ext_lvl)
  );

  irq_int_arb #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (int_req_i),
    .mask_i (int_mask_i),
    .clr_i  (clr),
    .pend_o (pend),
    .act_o  (act),
    .sel_o  (sel_idx)
  );

  assign ack4 = iack_i && (iack_level_i == LVL_INT);

  always_comb begin
    clr = '0;
    if (ack4 && sel_idx != NONE) clr[sel_idx] = 1'b1;
  end

  assign win_lvl = (|act && ext_lvl < LVL_INT) ? LVL_INT : ext_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ipl_no     <= 3'b111;
      iack_idx_o <= NONE;
    end else begin
      ipl_no <= 3'd7 - win_lvl;
      if (ack4) iack_idx_o <= sel_idx;
    end
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_SRC = NSRC,
  parameter int unsigned IDX_W = IDXW
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       ext_lvl,
  input logic [N_SRC-1:0] act,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] int_req_i,
  input logic [IDX_W-1:0] sel_idx,
  input logic             iack_i,
  input logic [2:0]       iack_level_i,
  input logic [2:0]       ipl_no,
  input logic [IDX_W-1:0] iack_idx_o
);
  localparam int unsigned W = 2 ** IDX_W;
  localparam logic [IDX_W-1:0] NONE = {IDX_W{1'b1}};
  logic [W-1:0] pend_x, req_x, multi_x;
  assign pend_x  = W'(pend);
  assign req_x   = W'(int_req_i);
  assign multi_x = W'(MULTI_EVT);

  // R2
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == '0 && ext_lvl == 3'd0) |=> ipl_no == 3'b111);

  // R6
  int_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|act) |=> ipl_no <= 3'b011);

  // R9
  ack_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_i && iack_level_i == 3'd4) |=> iack_idx_o == $past(sel_idx));

  // R10
  single_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_i && iack_level_i == 3'd4 && sel_idx != NONE &&
     !multi_x[sel_idx] && !req_x[sel_idx]) |=> !pend_x[$past(sel_idx)]);
endmodule

bind irq_prio_ctrl irq_prio_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ext_lvl      (ext_lvl),
  .act          (act),
  .pend         (pend),
  .int_req_i    (int_req_i),
  .sel_idx      (sel_idx),
  .iack_i       (iack_i),
  .iack_level_i (iack_level_i),
  .ipl_no       (ipl_no),
  .iack_idx_o   (iack_idx_o)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic [2:0]  enc = 3'b111;
  logic        p7 = 1'b1, p6 = 1'b1, p1 = 1'b1;
  logic [14:0] req = '0, mask = '0;
  logic        ack = 1'b0;
  logic [2:0]  ack_lvl = 3'd0;
  logic [2:0]  ipl;
  logic [3:0]  idx;

  int n_checks = 0, n_fail = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dedicated_mode_i(mode), .ext_ipl_ni(enc),
    .ded_irq7_ni(p7), .ded_irq6_ni(p6), .ded_irq1_ni(p1),
    .int_req_i(req), .int_mask_i(mask), .iack_i(ack), .iack_level_i(ack_lvl),
    .ipl_no(ipl), .iack_idx_o(idx)
  );

  // behavioural reference
  int multi_list[$] = '{2, 4, 5, 6, 7, 9};
  bit m_pend[15];
  int m_s1[6], m_s2[6];
  int exp_lvl = 0, exp_idx = 15;

  function automatic bit is_multi(int i);
    foreach (multi_list[k]) if (multi_list[k] == i) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int ext_level(int s[6], bit ded);
    int code, l;
    if (ded) begin
      if (s[3] == 0) return 7;
      if (s[4] == 0) return 6;
      if (s[5] == 0) return 1;
      return 0;
    end
    code = s[0] + 2 * s[1] + 4 * s[2];
    l = 7 - code;
    return (l == 4) ? 0 : l;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_pend[i]) m_pend[i] = 1'b0;
      foreach (m_s1[i]) begin m_s1[i] = 1; m_s2[i] = 1; end
      exp_lvl = 0;
      exp_idx = 15;
    end else begin
      int e, best;
      bit any;
      e = ext_level(m_s2, mode);
      best = 15;
      any = 1'b0;
      for (int i = 0; i < 15; i++) begin
        bit a;
        a = (is_multi(i) ? req[i] : m_pend[i]) && !mask[i];
        if (a) begin
          any = 1'b1;
          if (best == 15) best = i;
        end
      end
      exp_lvl = (any && e < 4) ? 4 : e;
      if (ack && ack_lvl == 3'd4) begin
        exp_idx = best;
        if (best != 15 && !is_multi(best)) m_pend[best] = 1'b0;
      end
      for (int i = 0; i < 15; i++)
        if (!is_multi(i) && req[i]) m_pend[i] = 1'b1;
      m_s2 = m_s1;
      m_s1 = '{int'(enc[0]), int'(enc[1]), int'(enc[2]), int'(p7), int'(p6), int'(p1)};
    end
  end

  task automatic check(string r, string what, int act_v, int exp_v);
    n_checks++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", r, what, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "ipl_no", int'(ipl), 7 - exp_lvl);
      check(cur_req, "iack_idx_o", int'(idx), exp_idx);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int i);
    req[i] = 1'b1;
    tick(1);
    req[i] = 1'b0;
  endtask

  task automatic ack_at(logic [2:0] l);
    ack = 1'b1; ack_lvl = l;
    tick(1);
    ack = 1'b0; ack_lvl = 3'd0;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", "reset ipl", int'(ipl), 7);
    check("R1", "reset idx", int'(idx), 15);
    tick(3);

    // R5 synchronizer latency
    cur_req = "R5";
    enc = 3'b000;
    tick(1); check("R5", "lat1", int'(ipl), 7);
    tick(1); check("R5", "lat2", int'(ipl), 7);
    tick(1); check("R5", "lat3", int'(ipl), 0);
    enc = 3'b111;
    tick(4);

    // R3 encoded sweep, code 011 ignored
    cur_req = "R3";
    for (int c = 0; c < 8; c++) begin
      enc = 3'(c);
      p7 = 1'b0;
      tick(5);
    end
    enc = 3'b011; tick(4);
    check("R3", "code 011 ignored", int'(ipl), 7);
    enc = 3'b111; p7 = 1'b1; tick(4);

    // R4 dedicated pins, encoded ignored
    cur_req = "R4";
    mode = 1'b1;
    enc = 3'b000; tick(4);
    check("R4", "enc ignored", int'(ipl), 7);
    p1 = 1'b0; tick(4);
    p6 = 1'b0; tick(4);
    p7 = 1'b0; tick(4);
    check("R4", "pin7 wins", int'(ipl), 0);
    p7 = 1'b1; tick(4);
    p6 = 1'b1; p1 = 1'b1; tick(4);
    mode = 1'b0; enc = 3'b111; tick(4);

    // R6 max of external and 4
    cur_req = "R6";
    pulse(14); tick(2);
    check("R6", "int only", int'(ipl), 3);
    enc = 3'b010; tick(4);
    check("R6", "ext5 over int", int'(ipl), 2);
    enc = 3'b100; tick(4);
    check("R6", "int over ext3", int'(ipl), 3);
    enc = 3'b111;
    ack_at(3'd4); tick(2);

    // R7 fixed order, R10 single-event clear
    cur_req = "R7";
    req = 15'h7D0B;  // 0,1,3,8,10,11,12,13,14 (single) plus 14 etc
    tick(1); req = '0;
    for (int k = 0; k < 10; k++) begin ack_at(3'd4); tick(1); end
    cur_req = "R10";
    pulse(3);
    req[3] = 1'b1; ack = 1'b1; ack_lvl = 3'd4; tick(1);
    req[3] = 1'b0; ack = 1'b0; tick(2);
    check("R10", "repulse keeps pending", int'(ipl), 3);
    ack_at(3'd4); tick(2);
    check("R10", "cleared", int'(ipl), 7);

    // R8 mask
    cur_req = "R8";
    mask[1] = 1'b1;
    pulse(1); tick(2);
    check("R8", "masked no level", int'(ipl), 7);
    ack_at(3'd4); tick(1);
    check("R8", "masked not granted", int'(idx), 15);
    mask[1] = 1'b0; tick(2);
    check("R8", "unmasked requests", int'(ipl), 3);
    ack_at(3'd4); tick(1);
    check("R8", "granted after unmask", int'(idx), 1);

    // R11 multi-event stays through ack
    cur_req = "R11";
    req[6] = 1'b1; req[9] = 1'b1;
    tick(1);
    ack_at(3'd4); ack_at(3'd4); tick(1);
    check("R11", "timer1 held", int'(idx), 6);
    req[6] = 1'b0; tick(1);
    ack_at(3'd4); tick(1);
    check("R11", "next multi", int'(idx), 9);
    req[9] = 1'b0; tick(3);

    // R9 non-4 ack has no effect
    cur_req = "R9";
    pulse(0);
    ack_at(3'd5); ack_at(3'd7); tick(1);
    check("R9", "idx unchanged", int'(idx), 9);
    check("R9", "still pending", int'(ipl), 3);
    ack_at(3'd4); tick(1);
    check("R9", "granted", int'(idx), 0);

    // R2 random mix
    cur_req = "R2";
    for (int k = 0; k < 3000; k++) begin
      mode = 1'($urandom_range(0, 1));
      enc  = 3'($urandom);
      p7 = 1'($urandom_range(0, 3) != 0);
      p6 = 1'($urandom_range(0, 3) != 0);
      p1 = 1'($urandom_range(0, 3) != 0);
      req  = 15'($urandom) & 15'($urandom) & 15'($urandom);
      mask = 15'($urandom) & 15'($urandom);
      ack  = 1'($urandom_range(0, 2) == 0);
      ack_lvl = ($urandom_range(0, 1) == 0) ? 3'd4 : 3'($urandom);
      tick(1);
    end
    ack = 1'b0; req = '0;
    tick(4);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule